// File: doc/BRIEF.md
# Prescaled 16-bit Reference Timer Pair

This block holds two independent 16-bit up-counting timers behind one small register port. Each timer takes its count pulses from an external tick input, from the system clock, or from the system clock divided by sixteen. Those pulses then pass through two cascaded 8-bit divide stages, so one count step takes (psr+1)·(sps+1) source pulses. The counter is compared with a 16-bit reference value. A match raises a sticky event flag, which software clears by writing a one, and can drive an interrupt. In restart mode the counter returns to zero on a match. In free-run mode it keeps counting and wraps at the top of its range.

Stop and reset for both timers sit in one shared configuration byte. Stop freezes a timer where it is. Reset clears its running state but keeps what software programmed. Software typically stops and resets a timer, programs the mode, prescale, reference and starting count, clears any stale event, and then clears the stop bit.

Top module: `tmr_pair16`

## Requirements
- R1: Registers are addressed as {timer, field}, where address bit 3 selects timer 0 or 1 and bits 2:0 select the field: 0 mode, 1 primary prescale, 2 reference, 3 counter, 4 event, 7 shared configuration byte (the same byte from either timer). rd_data presents the addressed register one cycle after rd_addr is applied. After rst every register reads zero.
- R2: With the internal source selected (mode bits 2:1 = 01), the counter advances once every (psr+1)·(sps+1) clock cycles while running. psr is the primary prescale register and sps is mode bits 15:8.
- R3: With the slow source selected (mode bits 2:1 = 10), a further division by 16 applies, so the counter advances once every 16·(psr+1)·(sps+1) running cycles.
- R4: With mode bits 2:1 = 00, each running cycle in which the timer's ext_tick bit is high is one source pulse. With mode bits 2:1 = 11, the timer does not count.
- R5: In free-run mode (mode bit 3 clear), the counter keeps incrementing past the reference and wraps from 0xFFFF to 0x0000.
- R6: In restart mode (mode bit 3 set), a count step taken while the counter equals the reference loads zero instead of incrementing.
- R7: A count step taken while the counter equals the reference sets the reference event, which is event register bit 1. No event is raised before that step.
- R8: Writing the event register clears each flag whose data bit is one. Data bits that are zero leave the flags unchanged.
- R9: If a reference match and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R10: irq of a timer equals its event flag ANDed with mode bit 4, delayed by one cycle. It stays high until the flag is cleared or the enable is removed.
- R11: While a timer's stop bit is set, its counter and its prescaler phases hold their values. Clearing the stop bit resumes counting from the held phase.
- R12: While a timer's reset bit is set, its counter, prescaler phases and event flag are zero. The mode, prescale and reference registers keep their contents.
- R13: In the configuration byte, timer 0 uses bit 1 as stop and bit 0 as reset, and timer 1 uses bit 5 as stop and bit 4 as reset. Neither timer reacts to the other's bits.
- R14: A write to the counter loads the written value and takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {timer, field} |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address {timer, field} |
| rd_data | output | 16 | Registered read data |
| ext_tick | input | 2 | External source pulse, one bit per timer |
| irq | output | 2 | Interrupt per timer |

## Verification
The hardest case to reach is a write-one-to-clear that lands on exactly the clock edge where a count step meets the reference. The port gives no direct view of that edge. The bench runs a restart-mode timer from a known zero phase and counts edges from the write that clears the stop bit. It then issues the clear so that it is captured on the fourth count step, where the counter equals a reference of 3. The flag must read back set afterwards. A counter write that coincides with a count step is reached the same way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'b00,
    SRC_INT  = 2'b01,
    SRC_SLOW = 2'b10,
    SRC_OFF  = 2'b11
  } clk_src_e;

  localparam logic [2:0] F_MODE = 3'd0;
  localparam logic [2:0] F_PSR  = 3'd1;
  localparam logic [2:0] F_REF  = 3'd2;
  localparam logic [2:0] F_CNT  = 3'd3;
  localparam logic [2:0] F_EVT  = 3'd4;
  localparam logic [2:0] F_CFG  = 3'd7;

  localparam int MB_SRC_LO  = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IEN     = 4;
  localparam int MB_SPS_LO  = 8;
  localparam int EV_REF_BIT = 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic [1:0]      src,
  input  logic            ext_tick,
  input  logic [PS_W-1:0] psr,
  input  logic [PS_W-1:0] sps,
  output logic            tick
);
  localparam int SD_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SD_W-1:0] SD_LAST = SD_W'(SLOW_DIV - 1);

  logic [SD_W-1:0] sd_q;
  logic [PS_W-1:0] p_q;
  logic [PS_W-1:0] s_q;
  logic            src_tick;
  logic            p_tick;

  always_comb begin
    case (clk_src_e'(src))
      SRC_EXT:  src_tick = ext_tick;
      SRC_INT:  src_tick = 1'b1;
      SRC_SLOW: src_tick = (sd_q == SD_LAST);
      default:  src_tick = 1'b0;
    endcase
  end

  assign p_tick = run && src_tick && (p_q >= psr);
  assign tick   = p_tick && (s_q >= sps);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sd_q <= '0;
      p_q  <= '0;
      s_q  <= '0;
    end else if (run) begin
      sd_q <= (sd_q == SD_LAST) ? '0 : sd_q + SD_W'(1);
      if (src_tick)
        p_q <= (p_q >= psr) ? '0 : p_q + PS_W'(1);
      if (p_tick)
        s_q <= (s_q >= sps) ? '0 : s_q + PS_W'(1);
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic             clr,
  input  logic             ext_tick,
  input  logic             wr_mode,
  input  logic             wr_psr,
  input  logic             wr_ref,
  input  logic             wr_cnt,
  input  logic             wr_evt,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] mode_o,
  output logic [PS_W-1:0]  psr_o,
  output logic [CNT_W-1:0] ref_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             irq_o
);
  logic [1:0]       src_q;
  logic             restart_q;
  logic             ien_q;
  logic [PS_W-1:0]  sps_q;
  logic [PS_W-1:0]  psr_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_q;
  logic             irq_q;
  logic             tick;
  logic             hit;

  tmr_prescale #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) u_ps (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .run      (!stop),
    .src      (src_q),
    .ext_tick (ext_tick),
    .psr      (psr_q),
    .sps      (sps_q),
    .tick     (tick)
  );

  assign hit = tick && (cnt_q == ref_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      restart_q <= 1'b0;
      ien_q     <= 1'b0;
      sps_q     <= '0;
      psr_q     <= '0;
      ref_q     <= '0;
    end else begin
      if (wr_mode) begin
        src_q     <= wdata[MB_SRC_LO +: 2];
        restart_q <= wdata[MB_RESTART];
        ien_q     <= wdata[MB_IEN];
        sps_q     <= wdata[MB_SPS_LO +: PS_W];
      end
      if (wr_psr) psr_q <= wdata[PS_W-1:0];
      if (wr_ref) ref_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (wr_cnt)
        cnt_q <= wdata;
      else if (tick)
        cnt_q <= (hit && restart_q) ? '0 : cnt_q + CNT_W'(1);
      evt_q <= (evt_q && !(wr_evt && wdata[EV_REF_BIT])) || hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= evt_q && ien_q;
  end

  always_comb begin
    mode_o                     = '0;
    mode_o[MB_SRC_LO +: 2]     = src_q;
    mode_o[MB_RESTART]         = restart_q;
    mode_o[MB_IEN]             = ien_q;
    mode_o[MB_SPS_LO +: PS_W]  = sps_q;
  end

  assign psr_o = psr_q;
  assign ref_o = ref_q;
  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_pair16.sv
module tmr_pair16
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16,
  localparam int ADDR_W  = 4,
  localparam int N_TMR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_TMR-1:0]  ext_tick,
  output logic [N_TMR-1:0]  irq
);
  logic [7:0]                  cfg_q;
  logic [N_TMR-1:0][CNT_W-1:0] mode_w;
  logic [N_TMR-1:0][PS_W-1:0]  psr_w;
  logic [N_TMR-1:0][CNT_W-1:0] ref_w;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_w;
  logic [N_TMR-1:0]            evt_w;
  logic [2:0]                  wf;
  logic [2:0]                  rf;
  logic                        rt;

  assign wf = wr_addr[2:0];
  assign rf = rd_addr[2:0];
  assign rt = rd_addr[3];

  always_ff @(posedge clk) begin
    if (rst)                       cfg_q <= '0;
    else if (wr_en && wf == F_CFG) cfg_q <= wr_data[7:0];
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    localparam int SB = (t % 2 == 1) ? 5 : 1;
    localparam int RB = SB - 1;
    logic sel;
    assign sel = wr_en && (wr_addr[3] == 1'(t));

    tmr_core #(.CNT_W(CNT_W), .PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) u_core (
      .clk      (clk),
      .rst      (rst),
      .stop     (cfg_q[SB]),
      .clr      (cfg_q[RB]),
      .ext_tick (ext_tick[t]),
      .wr_mode  (sel && wf == F_MODE),
      .wr_psr   (sel && wf == F_PSR),
      .wr_ref   (sel && wf == F_REF),
      .wr_cnt   (sel && wf == F_CNT),
      .wr_evt   (sel && wf == F_EVT),
      .wdata    (wr_data),
      .mode_o   (mode_w[t]),
      .psr_o    (psr_w[t]),
      .ref_o    (ref_w[t]),
      .cnt_o    (cnt_w[t]),
      .evt_o    (evt_w[t]),
      .irq_o    (irq[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rf)
        F_MODE:  rd_data <= mode_w[rt];
        F_PSR:   rd_data <= {{(CNT_W-PS_W){1'b0}}, psr_w[rt]};
        F_REF:   rd_data <= ref_w[rt];
        F_CNT:   rd_data <= cnt_w[rt];
        F_EVT:   rd_data <= {{(CNT_W-2){1'b0}}, evt_w[rt], 1'b0};
        F_CFG:   rd_data <= {{(CNT_W-8){1'b0}}, cfg_q};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_pair16_chk.sv
module tmr_pair16_chk #(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [3:0]           wr_addr,
  input logic                 wr_b1,
  input logic [1:0]           stp,
  input logic [1:0]           clr,
  input logic [1:0]           ien,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [1:0]           evt,
  input logic [1:0]           irq
);
  for (genvar t = 0; t < 2; t++) begin : g_chk
    logic wcnt;
    logic wclr;
    assign wcnt = wr_en && (wr_addr == {1'(t), 3'd3});
    assign wclr = wr_en && (wr_addr == {1'(t), 3'd4}) && wr_b1;

    // R10: interrupt tracks flag and enable one cycle later
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> irq[t] == $past(evt[t] && ien[t]));

    // R11: a stopped timer keeps its count
    p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (stp[t] && !clr[t] && !wcnt) |=> $stable(cnt[t]));

    // R12: reset bit zeroes count and flag
    p_clr_zero_r12: assert property (@(posedge clk) disable iff (rst)
      clr[t] |=> (cnt[t] == '0) && !evt[t]);

    // R8: flag persists unless cleared by a one or by the reset bit
    p_evt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (evt[t] && !clr[t] && !wclr) |=> evt[t]);

    // R5: without a write the count holds, steps by one, or returns to zero
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
      (!wcnt && !clr[t]) |=>
        (cnt[t] == $past(cnt[t])) || (cnt[t] == $past(cnt[t]) + CNT_W'(1)) || (cnt[t] == '0));
  end
endmodule

bind tmr_pair16 tmr_pair16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_b1   (wr_data[1]),
  .stp     ({cfg_q[5], cfg_q[1]}),
  .clr     ({cfg_q[4], cfg_q[0]}),
  .ien     ({mode_w[1][4], mode_w[0][4]}),
  .cnt     (cnt_w),
  .evt     (evt_w),
  .irq     (irq)
);

// File: tb/sim_tmr_pair16.sv
module sim_tmr_pair16;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  ext_tick = '0;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  tmr_pair16 u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_tick(ext_tick), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  localparam logic [2:0] MODE = 0, PSR = 1, REFV = 2, CNT = 3, EVT = 4, CFG = 7;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic t, input logic [2:0] f, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {t, f}; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic t, input logic [2:0] f, output logic [15:0] d);
    @(negedge clk);
    rd_addr = {t, f};
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // both timers stopped, running state zeroed, then one timer programmed
  task automatic prep(input logic t, input logic [15:0] m, input logic [15:0] p,
                      input logic [15:0] r, input logic [15:0] c);
    wr(0, CFG, 16'h0033);
    wr(0, CFG, 16'h0022);
    wr(t, MODE, m);
    wr(t, PSR, p);
    wr(t, REFV, r);
    wr(t, CNT, c);
    wr(t, EVT, 16'hFFFF);
  endtask

  // exactly k running edges for timer t
  task automatic run_for(input logic t, input int k);
    wr(0, CFG, t ? 16'h0002 : 16'h0020);
    repeat (k - 1) @(posedge clk);
    wr(0, CFG, 16'h0022);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, MODE, v); chk("R1 mode after reset", v, 16'h0000);
    rd(1, CNT, v);  chk("R1 count after reset", v, 16'h0000);
    rd(0, EVT, v);  chk("R1 event after reset", v, 16'h0000);
    rd(0, CFG, v);  chk("R1 cfg after reset", v, 16'h0000);
    chk("R10 irq after reset", {14'd0, irq}, 16'h0000);
  endtask

  task automatic t_free;
    logic [15:0] v;
    prep(0, 16'h0002, 0, 5, 0);
    run_for(0, 8);
    rd(0, CNT, v);  chk("R2 free count div1", v, 16'd8);
    rd(0, REFV, v); chk("R1 reference readback", v, 16'd5);
    rd(0, EVT, v);  chk("R7 event after passing ref", v, 16'h0002);
    repeat (10) @(posedge clk);
    rd(0, CNT, v);  chk("R11 stopped count holds", v, 16'd8);
    wr(0, EVT, 16'h0000);
    rd(0, EVT, v);  chk("R8 zero write keeps flag", v, 16'h0002);
    wr(0, EVT, 16'hFFFD);
    rd(0, EVT, v);  chk("R8 bit1 zero keeps flag", v, 16'h0002);
    wr(0, EVT, 16'h0002);
    rd(0, EVT, v);  chk("R8 one clears flag", v, 16'h0000);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    prep(0, 16'h000A, 0, 4, 0);
    run_for(0, 7);
    rd(0, CNT, v); chk("R6 restart count", v, 16'd2);
    rd(0, EVT, v); chk("R7 restart event", v, 16'h0002);
    prep(0, 16'h0002, 0, 10, 0);
    run_for(0, 5);
    rd(0, EVT, v); chk("R7 no event before ref", v, 16'h0000);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    prep(0, 16'h0102, 2, 16'hFFFF, 0);
    run_for(0, 20);
    rd(0, CNT, v); chk("R2 div 6 count", v, 16'd3);
    run_for(0, 4);
    rd(0, CNT, v); chk("R11 phase held over stop", v, 16'd4);
  endtask

  task automatic t_slow;
    logic [15:0] v;
    prep(0, 16'h0004, 0, 16'hFFFF, 0);
    run_for(0, 40);
    rd(0, CNT, v); chk("R3 slow source count", v, 16'd2);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    prep(0, 16'h0000, 0, 16'hFFFF, 0);
    wr(0, CFG, 16'h0020);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_tick[0] = 1'b1;
      @(posedge clk); #1 ext_tick[0] = 1'b0;
      repeat (2) @(posedge clk);
    end
    wr(0, CFG, 16'h0022);
    rd(0, CNT, v); chk("R4 external pulses", v, 16'd3);
    wr(0, MODE, 16'h0006);
    run_for(0, 10);
    rd(0, CNT, v); chk("R4 source off holds", v, 16'd3);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    prep(0, 16'h0012, 0, 2, 0);
    chk("R10 irq low before event", {15'd0, irq[0]}, 16'd0);
    run_for(0, 5);
    repeat (2) @(posedge clk); #1;
    chk("R10 irq high on event", {15'd0, irq[0]}, 16'd1);
    wr(0, MODE, 16'h0002);
    repeat (2) @(posedge clk); #1;
    chk("R10 irq low when disabled", {15'd0, irq[0]}, 16'd0);
    wr(0, MODE, 16'h0012);
    repeat (2) @(posedge clk); #1;
    chk("R10 irq back when enabled", {15'd0, irq[0]}, 16'd1);
    wr(0, EVT, 16'h0002);
    repeat (2) @(posedge clk); #1;
    chk("R10 irq low after clear", {15'd0, irq[0]}, 16'd0);
  endtask

  task automatic t_rstbit;
    logic [15:0] v;
    prep(0, 16'h0002, 0, 3, 0);
    run_for(0, 6);
    wr(0, CFG, 16'h0023);
    wr(0, CFG, 16'h0022);
    rd(0, CNT, v);  chk("R12 count zeroed", v, 16'd0);
    rd(0, EVT, v);  chk("R12 event zeroed", v, 16'd0);
    rd(0, REFV, v); chk("R12 reference kept", v, 16'd3);
    rd(0, MODE, v); chk("R12 mode kept", v, 16'h0002);
  endtask

  task automatic t_pair;
    logic [15:0] v;
    prep(1, 16'h0002, 0, 16'hFFFF, 0);
    wr(0, MODE, 16'h0002);
    wr(0, CNT, 16'd7);
    run_for(1, 5);
    rd(1, CNT, v); chk("R13 timer1 runs on bit5", v, 16'd5);
    rd(0, CNT, v); chk("R13 timer0 held by bit1", v, 16'd7);
    wr(0, CFG, 16'h0032);
    wr(0, CFG, 16'h0022);
    rd(1, CNT, v); chk("R13 timer1 reset on bit4", v, 16'd0);
    rd(0, CNT, v); chk("R13 timer0 ignores bit4", v, 16'd7);
  endtask

  task automatic t_setwins;
    logic [15:0] v;
    prep(0, 16'h000A, 0, 3, 0);
    wr(0, CFG, 16'h0020);
    repeat (3) @(posedge clk);
    wr(0, EVT, 16'h0002);
    wr(0, CFG, 16'h0022);
    rd(0, EVT, v); chk("R9 set wins over clear", v, 16'h0002);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    prep(0, 16'h0002, 0, 0, 16'hFFFE);
    run_for(0, 3);
    rd(0, CNT, v); chk("R5 wrap count", v, 16'd1);
    rd(0, EVT, v); chk("R5 event at zero ref", v, 16'h0002);
  endtask

  task automatic t_cntwr;
    logic [15:0] v;
    prep(0, 16'h0002, 0, 16'hFFFF, 0);
    wr(0, CFG, 16'h0020);
    repeat (2) @(posedge clk);
    wr(0, CNT, 16'h0100);
    wr(0, CFG, 16'h0022);
    rd(0, CNT, v); chk("R14 write beats step", v, 16'h0101);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_free();
    t_restart();
    t_prescale();
    t_slow();
    t_ext();
    t_irq();
    t_rstbit();
    t_pair();
    t_setwins();
    t_wrap();
    t_cntwr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule